// File: doc/BRIEF.md
# Paired-Access General Register File

This block is the general-purpose register storage of a 32-bit processor core. It holds thirty-two 32-bit entries. Two read ports and one write port each reach either one entry or a 64-bit pair of entries. A pair is formed by an odd entry, which carries the upper word, and the even entry just below it, which carries the lower word. Both access widths work on the same storage, so a value written as a pair can be read back as two single words, and the reverse.

The three highest entries also serve as the stack pointer (entry 29), the frame pointer (entry 30) and the return-address (link) register (entry 31). Subroutine-call and frame-setup operations update them through a separate implicit write path, with no explicit destination operand. Instruction decode, forwarding, control registers and memory access sit outside this block.

Reads are combinational. A write takes effect at the rising clock edge, so a read in the same cycle still sees the value from before the write.

Top module: `gpr_pair_file`

## Requirements
- R1: A synchronous active-high reset clears all 32 entries to zero, and every read after it returns zero.
- R2: When pair mode is off, a read port returns the addressed 32-bit entry in bits 31:0 and zero in bits 63:32. When pair mode is off, a write stores bits 31:0 of the write data into the addressed entry.
- R3: When pair mode is on, a read port returns the odd entry of the pair in bits 63:32 and the even entry in bits 31:0.
- R4: When pair mode is on, bit 0 of the index is ignored on both read and write ports. The pair is selected by index bits 4:1 alone.
- R5: A pair write stores bits 63:32 of the write data into the odd entry and bits 31:0 into the even entry, both at the same clock edge.
- R6: The implicit path writes the stack-pointer data into entry 29, the frame-pointer data into entry 30 and the link data into entry 31, each under its own enable.
- R7: If the explicit write and an implicit write target the same entry in the same cycle, the explicit data is stored. Implicit writes to entries the explicit write does not cover are still applied.
- R8: A read in the same cycle as a write to the same entry returns the old value. The new value is visible from the next cycle.
- R9: The two read ports are independent and may address different entries, in different modes, in the same cycle.
- R10: With the explicit write enable low, the write index and write data have no effect on the stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 5 | Read port A entry index |
| rd_a_pair | input | 1 | Read port A 64-bit pair mode |
| rd_a_data | output | 64 | Read port A data |
| rd_b_idx | input | 5 | Read port B entry index |
| rd_b_pair | input | 1 | Read port B 64-bit pair mode |
| rd_b_data | output | 64 | Read port B data |
| wr_en | input | 1 | Explicit write enable |
| wr_pair | input | 1 | Explicit write 64-bit pair mode |
| wr_idx | input | 5 | Explicit write entry index |
| wr_data | input | 64 | Explicit write data (bits 31:0 only in single mode) |
| imp_sp_en | input | 1 | Implicit stack-pointer write enable |
| imp_sp_data | input | 32 | Implicit stack-pointer data |
| imp_fp_en | input | 1 | Implicit frame-pointer write enable |
| imp_fp_data | input | 32 | Implicit frame-pointer data |
| imp_lr_en | input | 1 | Implicit link-register write enable |
| imp_lr_data | input | 32 | Implicit link-register data |

## Verification
The bench mixes single and pair writes to neighbouring entries and reads them back in the other width. This shows whether the halves land in the correct words and whether index bit 0 is truly ignored in pair mode. Reads are placed in the same cycle as writes to separate old-value from new-value behaviour. A disabled write carries live-looking data, to confirm that it stores nothing. Implicit writes are tried both alone and together with explicit single and pair writes that overlap them. This separates the override case from the case where both writes apply to different entries.

// File: rtl/gpr_pkg.sv
`timescale 1ns/1ps
package gpr_pkg;
  // Implicit-write roles; value is the offset from the first aliased entry.
  typedef enum logic [1:0] {
    ROLE_SP = 2'd0,
    ROLE_FP = 2'd1,
    ROLE_LR = 2'd2
  } alias_role_e;

  localparam int unsigned ALIAS_COUNT = 3;
endpackage

// File: rtl/gpr_write_steer.sv
`timescale 1ns/1ps
module gpr_write_steer #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned AW      = $clog2(NUM_REGS),
  localparam int unsigned NA      = gpr_pkg::ALIAS_COUNT
) (
  input  logic                           wr_en,
  input  logic                           wr_pair,
  input  logic [AW-1:0]                  wr_idx,
  input  logic [2*DATA_W-1:0]            wr_data,
  input  logic [NA-1:0]                  imp_en,
  input  logic [NA-1:0][DATA_W-1:0]      imp_data,
  output logic [NUM_REGS-1:0]            ent_we,
  output logic [NUM_REGS-1:0][DATA_W-1:0] ent_wd
);
  localparam int unsigned ALIAS_BASE = NUM_REGS - NA;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
    localparam logic [AW-1:0] IDX = AW'(i);
    logic exp_hit;
    logic [DATA_W-1:0] exp_word;

    // Pair mode compares only the upper index bits; the odd entry takes the high word.
    assign exp_hit  = wr_en && (wr_pair ? (wr_idx[AW-1:1] == IDX[AW-1:1])
                                        : (wr_idx == IDX));
    assign exp_word = (wr_pair && IDX[0]) ? wr_data[2*DATA_W-1:DATA_W]
                                          : wr_data[DATA_W-1:0];

    if (i >= ALIAS_BASE) begin : g_alias
      localparam int unsigned ROLE = i - ALIAS_BASE;
      // Explicit write has priority over the implicit path.
      assign ent_we[i] = exp_hit || imp_en[ROLE];
      assign ent_wd[i] = exp_hit ? exp_word : imp_data[ROLE];
    end else begin : g_plain
      assign ent_we[i] = exp_hit;
      assign ent_wd[i] = exp_word;
    end
  end
endmodule

// File: rtl/gpr_bank.sv
`timescale 1ns/1ps
module gpr_bank #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_REGS-1:0]             ent_we,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] ent_wd,
  output logic [NUM_REGS-1:0][DATA_W-1:0] regs
);
  always_ff @(posedge clk) begin
    if (rst) begin
      regs <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (ent_we[i]) regs[i] <= ent_wd[i];
      end
    end
  end
endmodule

// File: rtl/gpr_read_port.sv
`timescale 1ns/1ps
module gpr_read_port #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned AW      = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
  input  logic [AW-1:0]                   idx,
  input  logic                            pair,
  output logic [2*DATA_W-1:0]             data
);
  logic [AW-1:0] odd_idx;
  logic [AW-1:0] even_idx;

  assign odd_idx  = {idx[AW-1:1], 1'b1};
  assign even_idx = {idx[AW-1:1], 1'b0};

  always_comb begin
    if (pair) data = {regs[odd_idx], regs[even_idx]};
    else      data = {{DATA_W{1'b0}}, regs[idx]};
  end
endmodule

// File: rtl/gpr_pair_file.sv
`timescale 1ns/1ps
module gpr_pair_file #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned AW      = $clog2(NUM_REGS),
  localparam int unsigned NA      = gpr_pkg::ALIAS_COUNT
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [AW-1:0]       rd_a_idx,
  input  logic                rd_a_pair,
  output logic [2*DATA_W-1:0] rd_a_data,
  input  logic [AW-1:0]       rd_b_idx,
  input  logic                rd_b_pair,
  output logic [2*DATA_W-1:0] rd_b_data,
  input  logic                wr_en,
  input  logic                wr_pair,
  input  logic [AW-1:0]       wr_idx,
  input  logic [2*DATA_W-1:0] wr_data,
  input  logic                imp_sp_en,
  input  logic [DATA_W-1:0]   imp_sp_data,
  input  logic                imp_fp_en,
  input  logic [DATA_W-1:0]   imp_fp_data,
  input  logic                imp_lr_en,
  input  logic [DATA_W-1:0]   imp_lr_data
);
  import gpr_pkg::*;

  logic [NA-1:0]                   imp_en;
  logic [NA-1:0][DATA_W-1:0]       imp_data;
  logic [NUM_REGS-1:0]             ent_we;
  logic [NUM_REGS-1:0][DATA_W-1:0] ent_wd;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  always_comb begin
    imp_en   = '0;
    imp_data = '0;
    imp_en[ROLE_SP]   = imp_sp_en;
    imp_data[ROLE_SP] = imp_sp_data;
    imp_en[ROLE_FP]   = imp_fp_en;
    imp_data[ROLE_FP] = imp_fp_data;
    imp_en[ROLE_LR]   = imp_lr_en;
    imp_data[ROLE_LR] = imp_lr_data;
  end

  gpr_write_steer #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_steer (
    .wr_en    (wr_en),
    .wr_pair  (wr_pair),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .imp_en   (imp_en),
    .imp_data (imp_data),
    .ent_we   (ent_we),
    .ent_wd   (ent_wd)
  );

  gpr_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .ent_we (ent_we),
    .ent_wd (ent_wd),
    .regs   (regs)
  );

  gpr_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd_a (
    .regs (regs),
    .idx  (rd_a_idx),
    .pair (rd_a_pair),
    .data (rd_a_data)
  );

  gpr_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd_b (
    .regs (regs),
    .idx  (rd_b_idx),
    .pair (rd_b_pair),
    .data (rd_b_data)
  );
endmodule

// File: rtl/gpr_pair_file_chk.sv
`timescale 1ns/1ps
module gpr_pair_file_chk #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned AW      = $clog2(NUM_REGS)
) (
  input logic                clk,
  input logic                rst,
  input logic [AW-1:0]       rd_a_idx,
  input logic                rd_a_pair,
  input logic [2*DATA_W-1:0] rd_a_data,
  input logic [AW-1:0]       rd_b_idx,
  input logic                rd_b_pair,
  input logic [2*DATA_W-1:0] rd_b_data,
  input logic                wr_en,
  input logic                wr_pair,
  input logic [AW-1:0]       wr_idx,
  input logic [2*DATA_W-1:0] wr_data,
  input logic                imp_sp_en,
  input logic [DATA_W-1:0]   imp_sp_data,
  input logic                imp_fp_en,
  input logic [DATA_W-1:0]   imp_fp_data,
  input logic                imp_lr_en,
  input logic [DATA_W-1:0]   imp_lr_data
);
  localparam logic [AW-1:0] SP_IDX = AW'(NUM_REGS - 3);
  localparam logic [AW-1:0] FP_IDX = AW'(NUM_REGS - 2);
  localparam logic [AW-1:0] LR_IDX = AW'(NUM_REGS - 1);

  function automatic logic covers(input logic [AW-1:0] e);
    return wr_en && (wr_pair ? (wr_idx[AW-1:1] == e[AW-1:1]) : (wr_idx == e));
  endfunction

  logic cov_sp, cov_fp, cov_lr;
  assign cov_sp = covers(SP_IDX);
  assign cov_fp = covers(FP_IDX);
  assign cov_lr = covers(LR_IDX);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_a_data == '0 && rd_b_data == '0));

  assert_single_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_a_pair |-> rd_a_data[2*DATA_W-1:DATA_W] == '0);

  assert_single_write_seen_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en && !wr_pair && !rst) && !rd_a_pair && rd_a_idx == $past(wr_idx))
    |-> rd_a_data[DATA_W-1:0] == $past(wr_data[DATA_W-1:0]));

  assert_pair_write_seen_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en && wr_pair && !rst) && rd_a_pair &&
     rd_a_idx[AW-1:1] == $past(wr_idx[AW-1:1]))
    |-> rd_a_data == $past(wr_data));

  assert_implicit_lr_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(imp_lr_en && !cov_lr && !rst) && !rd_b_pair && rd_b_idx == LR_IDX)
    |-> rd_b_data[DATA_W-1:0] == $past(imp_lr_data));

  assert_implicit_sp_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(imp_sp_en && !cov_sp && !rst) && !rd_b_pair && rd_b_idx == SP_IDX)
    |-> rd_b_data[DATA_W-1:0] == $past(imp_sp_data));

  assert_explicit_over_fp_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(imp_fp_en && cov_fp && !wr_pair && !rst) && !rd_b_pair && rd_b_idx == FP_IDX)
    |-> rd_b_data[DATA_W-1:0] == $past(wr_data[DATA_W-1:0]));

  assert_implicit_fp_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(imp_fp_en && !cov_fp && !rst) && !rd_b_pair && rd_b_idx == FP_IDX)
    |-> rd_b_data[DATA_W-1:0] == $past(imp_fp_data));
endmodule

bind gpr_pair_file gpr_pair_file_chk #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_gpr_pair_file.sv
`timescale 1ns/1ps
module test_gpr_pair_file;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic        rd_a_pair = 1'b0, rd_b_pair = 1'b0, wr_en = 1'b0, wr_pair = 1'b0;
  logic [63:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        imp_sp_en = 1'b0, imp_fp_en = 1'b0, imp_lr_en = 1'b0;
  logic [31:0] imp_sp_data = '0, imp_fp_data = '0, imp_lr_data = '0;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  gpr_pair_file i_gpr_pair_file (.*);

  // Table: write applied at the edge after the row; read sampled before that edge.
  localparam int NV = 8;
  localparam logic        T_WEN [NV] = '{1, 1, 0, 1, 0, 1, 0, 1};
  localparam logic        T_WPR [NV] = '{0, 1, 0, 0, 0, 1, 0, 0};
  localparam logic [4:0]  T_WIX [NV] = '{5, 7, 0, 6, 5, 4, 0, 0};
  localparam logic [63:0] T_WDT [NV] = '{64'h11111111, 64'hAAAA0000_BBBB0001, 64'h0,
                                         64'h0000CCCC, 64'hDEAD, 64'h12345678_9ABCDEF0,
                                         64'h0, 64'hFFFFFFFF};
  localparam logic        T_RPR [NV] = '{0, 0, 1, 1, 1, 0, 1, 0};
  localparam logic [4:0]  T_RIX [NV] = '{5, 5, 6, 7, 6, 5, 5, 4};
  localparam logic [63:0] T_EXP [NV] = '{64'h0, 64'h11111111, 64'hAAAA0000_BBBB0001,
                                         64'hAAAA0000_BBBB0001, 64'hAAAA0000_0000CCCC,
                                         64'h11111111, 64'h12345678_9ABCDEF0, 64'h9ABCDEF0};
  localparam string       T_TAG [NV] = '{"R8", "R2", "R3", "R4", "R5", "R10", "R5", "R2"};

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 0; wr_pair = 0; wr_idx = '0; wr_data = '0;
    imp_sp_en = 0; imp_fp_en = 0; imp_lr_en = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: state after reset
    rd_a_pair = 1; rd_a_idx = 5'd31; rd_b_pair = 0; rd_b_idx = 5'd0;
    #1;
    check("R1 port A", rd_a_data, 64'h0);
    check("R1 port B", rd_b_data, 64'h0);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      wr_en = T_WEN[k]; wr_pair = T_WPR[k]; wr_idx = T_WIX[k]; wr_data = T_WDT[k];
      rd_a_pair = T_RPR[k]; rd_a_idx = T_RIX[k];
      rd_b_pair = 0; rd_b_idx = 5'd0;
      #1;
      check(T_TAG[k], rd_a_data, T_EXP[k]);
      check("R9 port B R0", rd_b_data, 64'h0);
    end

    // R9: both ports, different entries and modes
    @(negedge clk);
    idle_inputs();
    rd_a_pair = 0; rd_a_idx = 5'd0; rd_b_pair = 1; rd_b_idx = 5'd5;
    #1;
    check("R9 port A", rd_a_data, 64'hFFFFFFFF);
    check("R9 port B", rd_b_data, 64'h12345678_9ABCDEF0);

    // R6: implicit writes alone
    @(negedge clk);
    imp_sp_en = 1; imp_sp_data = 32'h1000;
    imp_fp_en = 1; imp_fp_data = 32'h2000;
    imp_lr_en = 1; imp_lr_data = 32'h3000;
    @(negedge clk);
    idle_inputs();
    rd_a_pair = 1; rd_a_idx = 5'd31; rd_b_pair = 0; rd_b_idx = 5'd29;
    #1;
    check("R6 fp/lr pair", rd_a_data, 64'h00003000_00002000);
    check("R6 sp", rd_b_data, 64'h1000);

    // R7: explicit single write to entry 30 with all implicit writes
    @(negedge clk);
    wr_en = 1; wr_pair = 0; wr_idx = 5'd30; wr_data = 64'h5555;
    imp_sp_en = 1; imp_sp_data = 32'h8888;
    imp_fp_en = 1; imp_fp_data = 32'h6666;
    imp_lr_en = 1; imp_lr_data = 32'h7777;
    @(negedge clk);
    idle_inputs();
    rd_a_pair = 1; rd_a_idx = 5'd30; rd_b_pair = 0; rd_b_idx = 5'd29;
    #1;
    check("R7 explicit fp, implicit lr", rd_a_data, 64'h00007777_00005555);
    check("R7 implicit sp kept", rd_b_data, 64'h8888);

    // R7: explicit pair write over 31:30 with all implicit writes
    @(negedge clk);
    wr_en = 1; wr_pair = 1; wr_idx = 5'd31; wr_data = 64'h00000099_000000AA;
    imp_sp_en = 1; imp_sp_data = 32'h1;
    imp_fp_en = 1; imp_fp_data = 32'h2;
    imp_lr_en = 1; imp_lr_data = 32'h3;
    @(negedge clk);
    idle_inputs();
    rd_a_pair = 1; rd_a_idx = 5'd29; rd_b_pair = 1; rd_b_idx = 5'd31;
    #1;
    check("R7 sp with pair neighbour", rd_a_data, 64'h00000001_00000000);
    check("R7 pair over fp/lr", rd_b_data, 64'h00000099_000000AA);

    // R1: reset in mid-run
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    rd_a_pair = 1; rd_a_idx = 5'd5; rd_b_pair = 1; rd_b_idx = 5'd31;
    #1;
    check("R1 rerun A", rd_a_data, 64'h0);
    check("R1 rerun B", rd_b_data, 64'h0);

    finish_run();
  end
endmodule